// File: doc/BRIEF.md
# External Bus Chip-Select Sequencer

This block drives the pins of an external memory interface that has separate address and data buses. Each bus clock cycle the processor side presents at most one read request. The request carries an address, a flag that says whether the target is external or on-chip ROM/RAM, and an area index from 0 to 3 that has already been decoded. From the current request and the state left by the previous one, the block decides whether the external address pins change, which of four active-low chip-select lines is asserted, and whether the read strobe pulses.

The block is built to keep pin activity low:

- The address pins keep the last external address through on-chip and idle cycles.
- A chip select stays low across back-to-back reads of the same area.
- An idle cycle freezes the address and the chip select together.

Because of these rules, one chip-select assertion can span many bus cycles. All outputs are registered, so a request reaches the pins one cycle after it is presented. Reads complete without wait states.

Top module: `ext_bus_cs_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, all chip selects are high, the address pins are all zero and the read strobe is high.
- R2: An external request to area index k (binary 0 to 3) drives, one cycle later, the address pins to the request address, chip select bit k low, every other chip select high, and the read strobe low.
- R3: An external request to area j that follows an external request to a different area i deasserts chip select i and asserts chip select j in the same cycle, and the address pins take the new address.
- R4: An on-chip request (valid, external flag low) drives all chip selects high one cycle later. The address pins keep their previous value, and the read strobe stays high.
- R5: An external request to the area whose chip select is already low keeps that chip select low with no high gap, while the address pins take the new address.
- R6: A cycle with no valid request keeps the address pins and all chip selects unchanged one cycle later, and the read strobe is high.
- R7: At no time is more than one chip select low.
- R8: Same-area reads with idle cycles between them hold a single chip-select assertion for more than two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A read request is present this cycle |
| req_ext | input | 1 | 1 = external area, 0 = on-chip ROM/RAM |
| req_area | input | 2 | Decoded external area index |
| req_addr | input | ADDR_W | Request address |
| ext_addr | output | ADDR_W | External address pins |
| cs_n | output | AREAS | Active-low chip selects, bit k for area k |
| rd_n | output | 1 | Active-low read strobe |

## Verification
The block's only state is the pins it drives, so a wrong internal decision shows up at the ports one cycle after the request that caused it. Examples are an address that moves during an idle cycle, a chip select that gaps between same-area reads, or a stale chip select left low after an on-chip access. The bench mirrors the pin rules in a behavioural model and compares every output on every cycle, so a fault is caught in the cycle it first appears. The test sequences walk through each transition pair between idle, on-chip, same-area and other-area cycles, so that every hold and change rule is exercised.

// File: rtl/ext_bus_cs_seq.sv
module ext_bus_cs_seq #(
  parameter int ADDR_W = 20,
  parameter int AREAS  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_ext,
  input  logic [$clog2(AREAS)-1:0]   req_area,
  input  logic [ADDR_W-1:0]          req_addr,
  output logic [ADDR_W-1:0]          ext_addr,
  output logic [AREAS-1:0]           cs_n,
  output logic                       rd_n
);
  localparam int IW = $clog2(AREAS);

  logic ext_go, int_go;
  logic [AREAS-1:0] sel_n;

  assign ext_go = req_valid && req_ext;
  assign int_go = req_valid && !req_ext;

  always_comb begin
    sel_n = '1;
    for (int k = 0; k < AREAS; k++)
      if (req_area == IW'(k)) sel_n[k] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_addr <= '0;
      cs_n     <= '1;
      rd_n     <= 1'b1;
    end else begin
      rd_n <= !ext_go;
      if (ext_go) begin
        ext_addr <= req_addr;
        cs_n     <= sel_n;
      end else if (int_go) begin
        cs_n <= '1;
      end
    end
  end

  // R7
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R2
  ext_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_go |=> (ext_addr == $past(req_addr)) && !rd_n && $countones(~cs_n) == 1);

  // R4
  int_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_go |=> (&cs_n) && rd_n && $stable(ext_addr));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(cs_n) && $stable(ext_addr) && rd_n);

  // R5
  same_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_go && !cs_n[req_area]) |=> $stable(cs_n));
endmodule

// File: tb/ext_bus_cs_seq_test.sv
module ext_bus_cs_seq_test;
  localparam int AW = 20;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ext = 0;
  logic [1:0] req_area = 0;
  logic [AW-1:0] req_addr = 0;
  logic [AW-1:0] ext_addr;
  logic [3:0] cs_n;
  logic rd_n;

  int checks = 0, errors = 0;
  int m_addr = 0;
  int m_area = -1;
  int m_rd = 1;
  int run_len = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  ext_bus_cs_seq uut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ext(req_ext),
    .req_area(req_area), .req_addr(req_addr), .ext_addr(ext_addr), .cs_n(cs_n), .rd_n(rd_n));

  function automatic logic [3:0] exp_cs();
    logic [3:0] v = 4'hF;
    if (m_area >= 0) v[m_area] = 1'b0;
    return v;
  endfunction

  task automatic compare();
    checks++;
    if (ext_addr !== AW'(m_addr) || cs_n !== exp_cs() || rd_n !== m_rd[0]) begin
      errors++;
      $display("FAIL %s addr=%h cs_n=%b rd_n=%b expected addr=%h cs_n=%b rd_n=%0d",
               tag, ext_addr, cs_n, rd_n, AW'(m_addr), exp_cs(), m_rd);
    end
    checks++;
    if ($countones(~cs_n) > 1) begin
      errors++;
      $display("FAIL R7 cs_n=%b expected at most one low", cs_n);
    end
  endtask

  // compare outputs of previous request, then apply a new one and update the model
  task automatic step(input bit v, input bit e, input int area, input int addr);
    @(negedge clk);
    compare();
    if (m_area >= 0 && v && e && area == m_area) run_len++;
    else if (!v && m_area >= 0) run_len++;
    else run_len = (v && e) ? 1 : 0;
    req_valid = v; req_ext = e; req_area = 2'(area); req_addr = AW'(addr);
    if (v && e) begin
      if (m_area >= 0 && m_area != area) tag = "R3";
      else if (m_area == area) tag = "R5";
      else tag = "R2";
      m_addr = addr; m_area = area; m_rd = 0;
    end else if (v) begin
      tag = "R4"; m_area = -1; m_rd = 1;
    end else begin
      tag = "R6"; m_rd = 1;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) begin @(negedge clk); tag = "R1"; compare(); end
    rst_n = 1;
    step(0, 0, 0, 0);
    tag = "R1";
    step(1, 1, 2, 'h1234);
    step(1, 1, 2, 'h1236);
    step(1, 1, 0, 'hABCDE);
    step(1, 0, 1, 'h00777);
    step(0, 0, 3, 'h55555);
    step(1, 1, 3, 'h0F0F0);
    step(0, 0, 0, 'h11111);
    step(1, 1, 3, 'h0F0F2);
    step(0, 0, 1, 'h22222);
    step(1, 1, 3, 'h0F0F4);
    @(negedge clk);
    checks++;
    if (run_len < 3) begin
      errors++;
      $display("FAIL R8 run=%0d expected >=3", run_len);
    end
    step(1, 1, 1, 'h3);
    step(1, 0, 0, 'h4);
    step(1, 0, 2, 'h5);
    step(1, 1, 1, 'h6);
    for (int n = 0; n < 400; n++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0,
           $urandom_range(0, 3), $urandom_range(0, (1 << AW) - 1));
    step(0, 0, 0, 0);
    @(negedge clk); compare();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule